// File: doc/BRIEF.md
# Burst Address Generator with Replay

This block produces the address for each access of a synchronous RAM port. In every clock cycle it picks one address from four sources. It can pass through an address supplied from outside, step its internal counter forward by one, keep the address it used last, or jump back to a saved replay address. The chosen address is on the output combinationally in the same cycle. At the rising edge that address is committed into the counter, so the next cycle continues from it.

Three active-low controls select the source: a strobe that accepts the outside address, a count enable, and a replay request. Replay has the highest priority, then the strobe, then the count enable. Every strobe also copies the outside address into a separate replay register, so a later replay returns to the newest accepted address. That register holds nothing meaningful until the first strobe. A flag shows when it has been filled, and a replay asked for before then leaves the address where it is. The counter wraps from the top of the address space to zero. The block has no chip or byte enables, so nothing gates the controls.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, with all three controls high, `addr_used` equals `RESET_ADDR` (default 0) and `rpt_valid` is 0.
- R2: When `repeat_n` is low and `rpt_valid` is 1, `addr_used` equals the `ext_addr` value taken at the most recent edge where `ads_n` was low, whatever `ads_n` and `cnten_n` are doing.
- R3: When `repeat_n` is high and `ads_n` is low, `addr_used` equals `ext_addr` in the same cycle.
- R4: When `repeat_n` and `ads_n` are high and `cnten_n` is low, `addr_used` equals the previous cycle's `addr_used` plus one.
- R5: When all three controls are high, `addr_used` equals the previous cycle's `addr_used`, and changes on `ext_addr` have no effect on it.
- R6: Every rising edge with `ads_n` low copies `ext_addr` into the replay register, including an edge where `repeat_n` is also low. A later replay returns the newest copy.
- R7: `rpt_valid` is 1 from the edge after the first cycle with `ads_n` low, and it stays 1 until reset.
- R8: When `repeat_n` is low while `rpt_valid` is 0, `addr_used` equals the previous cycle's `addr_used`.
- R9: Counting up from the all-ones address (2^ADDR_W − 1) gives address 0.
- R10: The address shown in a cycle is the one the next cycle continues from. After a replay, counting resumes from the replayed address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr | input | ADDR_W | Address supplied from outside |
| ads_n | input | 1 | Active-low strobe: use and capture `ext_addr` |
| cnten_n | input | 1 | Active-low count enable |
| repeat_n | input | 1 | Active-low replay request |
| addr_used | output | ADDR_W | Address selected for this cycle |
| rpt_valid | output | 1 | Replay register holds a captured address |

## Verification
A wrong counter value shows on `addr_used` in the very next hold or count cycle. It then carries into every later address until the next strobe or replay overwrites it. A corrupted replay register stays hidden until a replay is requested, possibly many cycles later. For that reason the stimulus issues replays often and after several back-to-back strobes. A misbehaving valid flag shows at once on `rpt_valid`, and also as a replay that either moves the address before any strobe or fails to move it afterwards.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

   // Source chosen for the address of the current cycle.
   typedef enum logic [1:0] {
      SEL_HOLD = 2'd0,
      SEL_INC  = 2'd1,
      SEL_LOAD = 2'd2,
      SEL_RPT  = 2'd3
   } addr_sel_e;

   localparam int unsigned MAX_ADDR_W = 32;

endpackage

// File: rtl/burst_addr_decode.sv
module burst_addr_decode
   import burst_addr_pkg::*;
(
   input  logic      ads_n,
   input  logic      cnten_n,
   input  logic      repeat_n,
   input  logic      rpt_filled,
   output addr_sel_e sel,
   output logic      capture
);

   // Priority order: replay, then strobe, then count enable.
   always_comb begin
      if (!repeat_n) begin
         sel = rpt_filled ? SEL_RPT : SEL_HOLD;
      end else if (!ads_n) begin
         sel = SEL_LOAD;
      end else if (!cnten_n) begin
         sel = SEL_INC;
      end else begin
         sel = SEL_HOLD;
      end
   end

   // The replay register follows every strobe, even one that replay overrides.
   assign capture = ~ads_n;

endmodule

// File: rtl/burst_addr_incr.sv
module burst_addr_incr #(
   parameter int unsigned WIDTH = 17
) (
   input  logic [WIDTH-1:0] val_in,
   output logic [WIDTH-1:0] val_out
);

   logic [WIDTH-1:0] carry;

   assign carry[0] = 1'b1;

   // Ripple increment. The carry out of the top bit is dropped, so the value wraps to zero.
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign val_out[b] = val_in[b] ^ carry[b];
      if (b < WIDTH - 1) begin : g_carry
         assign carry[b+1] = val_in[b] & carry[b];
      end
   end

endmodule

// File: rtl/burst_addr_regs.sv
module burst_addr_regs #(
   parameter int unsigned    ADDR_W     = 17,
   parameter longint unsigned RESET_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] next_addr,
   input  logic              capture,
   input  logic [ADDR_W-1:0] cap_addr,
   output logic [ADDR_W-1:0] cnt_q,
   output logic [ADDR_W-1:0] rpt_q,
   output logic              rpt_filled
);

   localparam logic [ADDR_W-1:0] RST_VAL = ADDR_W'(RESET_ADDR);

   // The counter always takes the address that was just used.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RST_VAL;
      end else begin
         cnt_q <= next_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rpt_q      <= '0;
         rpt_filled <= 1'b0;
      end else if (capture) begin
         rpt_q      <= cap_addr;
         rpt_filled <= 1'b1;
      end
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_addr_pkg::*;
#(
   parameter int unsigned     ADDR_W     = 17,
   parameter longint unsigned RESET_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              ads_n,
   input  logic              cnten_n,
   input  logic              repeat_n,
   output logic [ADDR_W-1:0] addr_used,
   output logic              rpt_valid
);

   localparam longint unsigned ADDR_SPAN = 64'd1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_width
      $error("burst_addr_gen: ADDR_W out of range");
   end
   if (RESET_ADDR >= ADDR_SPAN) begin : g_bad_reset
      $error("burst_addr_gen: RESET_ADDR does not fit ADDR_W");
   end

   addr_sel_e         sel;
   logic              capture;
   logic              rpt_filled;
   logic [ADDR_W-1:0] cnt_q;
   logic [ADDR_W-1:0] rpt_q;
   logic [ADDR_W-1:0] cnt_plus;

   burst_addr_decode u_dec (
      .ads_n      (ads_n),
      .cnten_n    (cnten_n),
      .repeat_n   (repeat_n),
      .rpt_filled (rpt_filled),
      .sel        (sel),
      .capture    (capture)
   );

   burst_addr_incr #(.WIDTH(ADDR_W)) u_inc (
      .val_in  (cnt_q),
      .val_out (cnt_plus)
   );

   always_comb begin
      unique case (sel)
         SEL_LOAD: addr_used = ext_addr;
         SEL_INC:  addr_used = cnt_plus;
         SEL_RPT:  addr_used = rpt_q;
         default:  addr_used = cnt_q;
      endcase
   end

   burst_addr_regs #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .next_addr  (addr_used),
      .capture    (capture),
      .cap_addr   (ext_addr),
      .cnt_q      (cnt_q),
      .rpt_q      (rpt_q),
      .rpt_filled (rpt_filled)
   );

   assign rpt_valid = rpt_filled;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int unsigned ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              ads_n,
   input logic              cnten_n,
   input logic              repeat_n,
   input logic [ADDR_W-1:0] addr_used,
   input logic              rpt_valid
);

   logic              started;
   logic [ADDR_W-1:0] last_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started  <= 1'b0;
         last_cap <= '0;
      end else begin
         started <= 1'b1;
         if (!ads_n) last_cap <= ext_addr;
      end
   end

   assert_replay_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!repeat_n && rpt_valid) |-> addr_used == last_cap);

   assert_strobe_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (repeat_n && !ads_n) |-> addr_used == ext_addr);

   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (started && repeat_n && ads_n && !cnten_n) |-> addr_used == ADDR_W'($past(addr_used) + 1'b1));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (started && repeat_n && ads_n && cnten_n) |-> addr_used == $past(addr_used));

   assert_valid_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ads_n |=> rpt_valid);

   assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid |=> rpt_valid);

   assert_early_replay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !repeat_n && !rpt_valid) |-> addr_used == $past(addr_used));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ext_addr  (ext_addr),
   .ads_n     (ads_n),
   .cnten_n   (cnten_n),
   .repeat_n  (repeat_n),
   .addr_used (addr_used),
   .rpt_valid (rpt_valid)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;

   localparam int unsigned AW = 17;
   localparam logic [AW-1:0] TOP = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic          ads_n = 1'b1;
   logic          cnten_n = 1'b1;
   logic          repeat_n = 1'b1;
   logic [AW-1:0] addr_used;
   logic          rpt_valid;

   int n_vec = 0;
   int n_bad = 0;

   // Reference state
   logic [AW-1:0] m_cnt = '0;
   logic [AW-1:0] m_rpt = '0;
   logic          m_val = 1'b0;

   always #2.5 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_addr  (ext_addr),
      .ads_n     (ads_n),
      .cnten_n   (cnten_n),
      .repeat_n  (repeat_n),
      .addr_used (addr_used),
      .rpt_valid (rpt_valid)
   );

   function automatic logic [AW-1:0] expect_addr(logic a, logic c, logic r, logic [AW-1:0] e);
      if (!r)      return m_val ? m_rpt : m_cnt;
      else if (!a) return e;
      else if (!c) return AW'(m_cnt + 1'b1);
      else         return m_cnt;
   endfunction

   task automatic check(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // One cycle: drive after a falling edge, compare mid-cycle, update the model at the rising edge.
   task automatic step(string req, logic a, logic c, logic r, logic [AW-1:0] e);
      logic [AW-1:0] exp;
      @(negedge clk);
      ads_n = a; cnten_n = c; repeat_n = r; ext_addr = e;
      #1;
      exp = expect_addr(a, c, r, e);
      check(req, addr_used, exp);
      check({req, " valid R7"}, AW'(rpt_valid), AW'(m_val));
      @(posedge clk);
      m_cnt = exp;
      if (!a) begin m_rpt = e; m_val = 1'b1; end
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7031));
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset addr", addr_used, '0);
      check("R1 reset valid", AW'(rpt_valid), '0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 after release", addr_used, '0);
      // R8: replay before any strobe keeps the address
      step("R4 count", 1, 0, 1, 17'h0AAAA);
      step("R8 early replay", 1, 1, 0, 17'h01234);
      step("R8 early replay again", 0, 0, 0, 17'h05555);
      // The strobe above was overridden by replay but still captured (R6)
      step("R2 replay of overridden strobe R6", 1, 1, 0, '0);
      step("R10 count after replay", 1, 0, 1, '0);
      // R3 / R9 wrap
      step("R3 load top", 0, 1, 1, TOP - 1);
      step("R4 count to top", 1, 0, 1, '0);
      step("R9 wrap to zero", 1, 0, 1, '0);
      step("R5 hold ignores ext", 1, 1, 1, 17'h1F0F0);
      // R6 newest strobe wins
      step("R3 load a", 0, 0, 1, 17'h00100);
      step("R3 load b", 0, 1, 1, 17'h00200);
      step("R4 count", 1, 0, 1, '0);
      step("R2 replay newest R6", 0, 0, 0, 17'h00300);
      step("R2 replay newest R6", 1, 0, 0, '0);
      step("R10 resume from replay", 1, 0, 1, '0);
      // Constrained random
      for (int i = 0; i < 3000; i++) begin
         logic a, c, r;
         logic [AW-1:0] e;
         a = ($urandom % 5) != 0;
         c = ($urandom % 3) == 0;
         r = ($urandom % 6) != 0;
         e = ($urandom % 4 == 0) ? TOP - AW'($urandom % 3) : AW'($urandom);
         step("R2-R10 random", a, c, r, e);
      end
      // Reset again and re-check the flag
      @(negedge clk);
      rst_n = 1'b0;
      ads_n = 1'b1; cnten_n = 1'b1; repeat_n = 1'b1;
      #1;
      check("R1 re-reset valid", AW'(rpt_valid), '0);
      check("R1 re-reset addr", addr_used, '0);
      m_cnt = '0; m_val = 1'b0; m_rpt = '0;
      @(negedge clk);
      rst_n = 1'b1;
      step("R8 replay after re-reset", 1, 0, 0, 17'h00777);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule